// File: doc/BRIEF.md
# Interprocessor Interrupt Dispatch Unit

This unit lets the processors of a small multiprocessor system interrupt one another. It provides four interrupt channels. Each channel has a configuration register that sets its vector, its 4-bit priority and a mask bit. A processor raises a channel by writing a bitmask of destination processors to that channel's dispatch address. Every destination then holds its own pending bit for that channel. The unit keeps that pending bit until the destination takes the interrupt.

For each processor the unit offers one candidate to a downstream delivery arbiter. The candidate is the most urgent pending, unmasked channel, with its vector and channel number. When the arbiter acknowledges the candidate, the pending bit at that processor moves to an in-service bit. The processor's end-of-interrupt strobe later retires the most urgent in-service channel. While a channel is in service at a processor, only a strictly more urgent channel can be offered to that processor. Software usually gives channels 0 to 3 the priorities 10 to 13, so a higher channel number carries a higher priority.

Top module: `ipi_dispatch_unit`

## Requirements
- R1: After reset no processor has a pending or in-service channel and `irq_valid` is all zero. Every channel reads back as mask=1, priority 0, vector 0, which is 32'h8000_0000.
- R2: A write with `addr[3]`=0 and channel `addr[2:0]` updates that channel's configuration from vector `wr_data[7:0]`, priority `wr_data[19:16]` and mask `wr_data[31]`. A read of the same address returns these fields in the same positions, plus the activity bit in bit 30. Every other bit reads 0, and bit 30 cannot be written.
- R3: A write with `addr[3]`=1 is a dispatch to channel `addr[2:0]`. It sets that channel pending at each processor k < NUM_CPU whose bit `wr_data[k]` is 1. Higher data bits are ignored, and a dispatch value whose processor bits are all zero changes nothing.
- R4: Channel numbers 4 to 7 are invalid. Writes to them, whether configuration or dispatch, have no effect, and reads of them return 0.
- R5: A masked channel is never offered. Its pending bits are kept and are offered once the channel is unmasked.
- R6: Among the eligible channels at a processor, the highest priority is offered. When priorities are equal, the lowest channel number wins.
- R7: For each processor the unit drives `irq_valid`, plus `irq_chan` and `irq_vec` taken from the offered channel's configuration. These outputs change only after a write, an acknowledge or an end-of-interrupt.
- R8: An acknowledge while `irq_valid` is set clears the offered channel's pending bit at that processor only and marks the channel in service there. An acknowledge while `irq_valid` is clear is ignored.
- R9: While any channel is in service at a processor, a pending channel is eligible there only if its priority is strictly greater than the highest in-service priority.
- R10: An end-of-interrupt retires the highest-priority in-service channel at that processor, choosing the lowest channel number on a tie. With nothing in service it has no effect.
- R11: Dispatching a channel that is already pending at a processor merges into the single pending bit. One acknowledge clears it.
- R12: The activity bit of a channel reads 1 while that channel is pending or in service at any processor.
- R13: If a dispatch and an acknowledge of the same channel at the same processor fall in one cycle, the channel stays pending there and also enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Bit 3 selects dispatch (1) or configuration (0); bits 2:0 select the channel |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ack | input | NUM_CPU | Per-processor acknowledge from the delivery arbiter |
| eoi | input | NUM_CPU | Per-processor end-of-interrupt strobe |
| irq_valid | output | NUM_CPU | Per-processor candidate present |
| irq_chan | output | 2*NUM_CPU | Channel number of each processor's candidate |
| irq_vec | output | 8*NUM_CPU | Vector of each processor's candidate |

## Verification
The bench drives the block through several corner cases:
- A priority tie between two channels at one processor. A design that resolved the tie the wrong way would offer channel 2 where channel 1 is required.
- An acknowledge followed by a re-dispatch of the same channel. A design without the in-service threshold would offer that channel again before its end-of-interrupt.
- Repeated dispatches to an already pending channel. A design that counted requests instead of merging them would offer the channel a second time after one acknowledge.
- A dispatch and an acknowledge of the same channel in one cycle. If clear took precedence over set, the new request would be lost and would not appear after the end-of-interrupt.
- Writes to channels 4 to 7, high dispatch bits, zero dispatches and stray acknowledges. A design that decoded these loosely would create pending state that shows up as a wrong candidate or a wrong activity bit.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  parameter int IPI_CHANS = 4;
  parameter int CHAN_W    = $clog2(IPI_CHANS);
  parameter int VEC_W     = 8;
  parameter int PRI_W     = 4;
  parameter int ADDR_W    = 4;
  parameter int DATA_W    = 32;

  localparam int SEL_W   = ADDR_W - 1;
  localparam int MASK_B  = DATA_W - 1;
  localparam int ACT_B   = DATA_W - 2;
  localparam int PRI_LSB = 16;
  localparam int VEC_LSB = 0;

  typedef struct packed {
    logic             mask;
    logic [PRI_W-1:0] pri;
    logic [VEC_W-1:0] vec;
  } chan_cfg_t;
endpackage

// File: rtl/ipi_cfg_regs.sv
module ipi_cfg_regs
  import ipi_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CHAN_W-1:0]             wr_chan,
  input  logic [DATA_W-1:0]             wr_data,
  output chan_cfg_t [IPI_CHANS-1:0]     cfg_o
);
  chan_cfg_t new_cfg;

  always_comb begin
    new_cfg.mask = wr_data[MASK_B];
    new_cfg.pri  = wr_data[PRI_LSB +: PRI_W];
    new_cfg.vec  = wr_data[VEC_LSB +: VEC_W];
  end

  for (genvar c = 0; c < IPI_CHANS; c++) begin : g_chan
    logic hit;
    assign hit = wr_en && (wr_chan == CHAN_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[c].mask <= 1'b1;
        cfg_o[c].pri  <= '0;
        cfg_o[c].vec  <= '0;
      end else if (hit) begin
        cfg_o[c] <= new_cfg;
      end
    end
  end
endmodule

// File: rtl/ipi_cpu_slot.sv
module ipi_cpu_slot
  import ipi_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  chan_cfg_t [IPI_CHANS-1:0] cfg,
  input  logic [IPI_CHANS-1:0]      raise,
  input  logic                      ack,
  input  logic                      eoi,
  output logic                      valid_o,
  output logic [CHAN_W-1:0]         chan_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [IPI_CHANS-1:0]      busy_o
);
  logic [IPI_CHANS-1:0] pend_q, pend_n, isv_q, isv_n;
  logic [IPI_CHANS-1:0] take_mask, done_mask;
  logic                 isv_any, sel_any, take, done, upd;
  logic [PRI_W-1:0]     isv_pri, sel_pri;
  logic [CHAN_W-1:0]    isv_top, sel_chan;

  // find the in-service ceiling and the best eligible pending channel
  always_comb begin
    isv_any  = 1'b0;
    isv_pri  = '0;
    isv_top  = '0;
    sel_any  = 1'b0;
    sel_pri  = '0;
    sel_chan = '0;
    for (int c = 0; c < IPI_CHANS; c++) begin
      if (isv_q[c] && (!isv_any || cfg[c].pri > isv_pri)) begin
        isv_any = 1'b1;
        isv_pri = cfg[c].pri;
        isv_top = CHAN_W'(c);
      end
    end
    for (int c = 0; c < IPI_CHANS; c++) begin
      if (pend_q[c] && !cfg[c].mask && (!isv_any || cfg[c].pri > isv_pri) &&
          (!sel_any || cfg[c].pri > sel_pri)) begin
        sel_any  = 1'b1;
        sel_pri  = cfg[c].pri;
        sel_chan = CHAN_W'(c);
      end
    end
  end

  // next state
  always_comb begin
    take      = ack && sel_any;
    done      = eoi && isv_any;
    take_mask = take ? (IPI_CHANS'(1) << sel_chan) : '0;
    done_mask = done ? (IPI_CHANS'(1) << isv_top) : '0;
    pend_n    = (pend_q & ~take_mask) | raise;
    isv_n     = (isv_q & ~done_mask) | take_mask;
    upd       = take || done || (|raise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isv_q  <= '0;
    end else if (upd) begin
      pend_q <= pend_n;
      isv_q  <= isv_n;
    end
  end

  assign valid_o = sel_any;
  assign chan_o  = sel_chan;
  assign vec_o   = cfg[sel_chan].vec;
  assign busy_o  = pend_q | isv_q;
endmodule

// File: rtl/ipi_dispatch_unit.sv
module ipi_dispatch_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [NUM_CPU-1:0]        ack,
  input  logic [NUM_CPU-1:0]        eoi,
  output logic [NUM_CPU-1:0]        irq_valid,
  output logic [NUM_CPU*CHAN_W-1:0] irq_chan,
  output logic [NUM_CPU*VEC_W-1:0]  irq_vec
);
  chan_cfg_t [IPI_CHANS-1:0] cfg_q;
  logic                      is_disp, chan_ok, cfg_wr, disp_wr;
  logic [SEL_W-1:0]          chan_idx;
  logic [CHAN_W-1:0]         chan_lo;
  logic [IPI_CHANS-1:0]      chan_hit;
  logic [IPI_CHANS-1:0]      busy [NUM_CPU];
  logic [IPI_CHANS-1:0]      active;

  assign is_disp  = addr[ADDR_W-1];
  assign chan_idx = addr[SEL_W-1:0];
  assign chan_lo  = chan_idx[CHAN_W-1:0];
  assign chan_ok  = (chan_idx < SEL_W'(IPI_CHANS));
  assign cfg_wr   = wr_en && !is_disp && chan_ok;
  assign disp_wr  = wr_en && is_disp && chan_ok;
  assign chan_hit = disp_wr ? (IPI_CHANS'(1) << chan_lo) : '0;

  ipi_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_chan (chan_lo),
    .wr_data (wr_data),
    .cfg_o   (cfg_q)
  );

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    logic [IPI_CHANS-1:0] raise_k;
    assign raise_k = wr_data[k] ? chan_hit : '0;

    ipi_cpu_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q),
      .raise   (raise_k),
      .ack     (ack[k]),
      .eoi     (eoi[k]),
      .valid_o (irq_valid[k]),
      .chan_o  (irq_chan[k*CHAN_W +: CHAN_W]),
      .vec_o   (irq_vec[k*VEC_W +: VEC_W]),
      .busy_o  (busy[k])
    );
  end

  always_comb begin
    active = '0;
    for (int k = 0; k < NUM_CPU; k++) active = active | busy[k];
  end

  always_comb begin
    rd_data = '0;
    if (!is_disp && chan_ok) begin
      rd_data[MASK_B]                = cfg_q[chan_lo].mask;
      rd_data[ACT_B]                 = active[chan_lo];
      rd_data[PRI_LSB +: PRI_W]      = cfg_q[chan_lo].pri;
      rd_data[VEC_LSB +: VEC_W]      = cfg_q[chan_lo].vec;
    end
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wr_data,
  input logic [NUM_CPU-1:0]        ack,
  input logic [NUM_CPU-1:0]        eoi,
  input logic [NUM_CPU-1:0]        irq_valid,
  input logic [NUM_CPU*CHAN_W-1:0] irq_chan,
  input logic [NUM_CPU*VEC_W-1:0]  irq_vec,
  input chan_cfg_t [IPI_CHANS-1:0] cfg_q
);
  for (genvar k = 0; k < NUM_CPU; k++) begin : g_k
    logic [CHAN_W-1:0] ch_k;
    assign ch_k = irq_chan[k*CHAN_W +: CHAN_W];

    // R5
    offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid[k] |-> !cfg_q[ch_k].mask);

    // R8
    ack_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[k] && irq_valid[k]) |=> !(irq_valid[k] && ch_k == $past(ch_k)));
  end

  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ack == '0 && eoi == '0) |=>
      ($stable(irq_valid) && $stable(irq_chan) && $stable(irq_vec)));

  // R3
  zero_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1] && wr_data[NUM_CPU-1:0] == '0 && ack == '0 && eoi == '0) |=>
      ($stable(irq_valid) && $stable(irq_chan) && $stable(irq_vec)));
endmodule

bind ipi_dispatch_unit ipi_dispatch_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wr_data   (wr_data),
  .ack       (ack),
  .eoi       (eoi),
  .irq_valid (irq_valid),
  .irq_chan  (irq_chan),
  .irq_vec   (irq_vec),
  .cfg_q     (cfg_q)
);

// File: tb/test_ipi_dispatch_unit.sv
`timescale 1ns/1ps
module test_ipi_dispatch_unit;
  localparam int NC = 4;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wr_en;
  logic [3:0]      addr;
  logic [31:0]     wr_data;
  logic [31:0]     rd_data;
  logic [NC-1:0]   ack, eoi, irq_valid;
  logic [2*NC-1:0] irq_chan;
  logic [8*NC-1:0] irq_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_pend [NC][NCH];
  int m_isv  [NC][NCH];
  int m_mask [NCH];
  int m_pri  [NCH];
  int m_vec  [NCH];

  always #5 clk = ~clk;

  ipi_dispatch_unit #(.NUM_CPU(NC)) i_ipi_dispatch_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ack(ack), .eoi(eoi), .irq_valid(irq_valid),
    .irq_chan(irq_chan), .irq_vec(irq_vec)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_ceiling(int k);
    int t = -1;
    for (int c = 0; c < NCH; c++)
      if (m_isv[k][c] != 0 && m_pri[c] > t) t = m_pri[c];
    return t;
  endfunction

  function automatic int m_sel(int k);
    int thr = m_ceiling(k);
    int best = -1;
    for (int c = 0; c < NCH; c++)
      if (m_pend[k][c] != 0 && m_mask[c] == 0 && m_pri[c] > thr &&
          (best < 0 || m_pri[c] > m_pri[best])) best = c;
    return best;
  endfunction

  function automatic int m_top(int k);
    int t = -1;
    for (int c = 0; c < NCH; c++)
      if (m_isv[k][c] != 0 && (t < 0 || m_pri[c] > m_pri[t])) t = c;
    return t;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] r = '0;
    int c = int'(a[2:0]);
    if (a[3] || c >= NCH) return r;
    r[31] = (m_mask[c] != 0);
    for (int k = 0; k < NC; k++)
      if (m_pend[k][c] != 0 || m_isv[k][c] != 0) r[30] = 1'b1;
    r[19:16] = 4'(m_pri[c]);
    r[7:0]   = 8'(m_vec[c]);
    return r;
  endfunction

  task automatic model_step();
    int sel [NC];
    int top [NC];
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_mask[c] = 1; m_pri[c] = 0; m_vec[c] = 0;
        for (int k = 0; k < NC; k++) begin m_pend[k][c] = 0; m_isv[k][c] = 0; end
      end
      return;
    end
    for (int k = 0; k < NC; k++) begin sel[k] = m_sel(k); top[k] = m_top(k); end
    for (int k = 0; k < NC; k++) begin
      if (eoi[k] && top[k] >= 0) m_isv[k][top[k]] = 0;
      if (ack[k] && sel[k] >= 0) begin m_pend[k][sel[k]] = 0; m_isv[k][sel[k]] = 1; end
    end
    if (wr_en && addr[2:0] < 3'(NCH)) begin
      if (addr[3]) begin
        for (int k = 0; k < NC; k++) if (wr_data[k]) m_pend[k][addr[1:0]] = 1;
      end else begin
        m_mask[addr[1:0]] = int'(wr_data[31]);
        m_pri[addr[1:0]]  = int'(wr_data[19:16]);
        m_vec[addr[1:0]]  = int'(wr_data[7:0]);
      end
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < NC; k++) begin
      int s = m_sel(k);
      chk(irq_valid[k] == (s >= 0), "R7 valid", 32'(irq_valid[k]), 32'(s >= 0));
      if (s >= 0) begin
        chk(irq_chan[2*k +: 2] == 2'(s), "R7 chan", 32'(irq_chan[2*k +: 2]), 32'(s));
        chk(irq_vec[8*k +: 8] == 8'(m_vec[s]), "R7 vec", 32'(irq_vec[8*k +: 8]), 32'(m_vec[s]));
      end
    end
    chk(rd_data == m_read(addr), "R2 read", rd_data, m_read(addr));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(logic [NC-1:0] a, logic [NC-1:0] e);
    ack = a; eoi = e;
    tick();
    ack = '0; eoi = '0;
  endtask

  task automatic expect_cpu(int k, bit v, int ch, int vec, string req);
    chk(irq_valid[k] == v, req, 32'(irq_valid[k]), 32'(v));
    if (v) begin
      chk(irq_chan[2*k +: 2] == 2'(ch), req, 32'(irq_chan[2*k +: 2]), 32'(ch));
      chk(irq_vec[8*k +: 8] == 8'(vec), req, 32'(irq_vec[8*k +: 8]), 32'(vec));
    end
  endtask

  task automatic expect_rd(logic [3:0] a, logic [31:0] exp, string req);
    addr = a;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0; ack = '0; eoi = '0;
    tick(); tick();
    // R1 reset state
    chk(irq_valid == '0, "R1 valid", 32'(irq_valid), 0);
    expect_rd(4'h0, 32'h8000_0000, "R1 cfg reset");
    rst_n = 1'b1;
    tick();

    // R2 configuration layout
    for (int c = 0; c < NCH; c++) wr(4'(c), 32'h8000_0000 | ((10 + c) << 16) | (8'h40 + c));
    expect_rd(4'h2, 32'h800C_0042, "R2 readback");
    wr(4'h0, 32'h7FFA_FF40);
    expect_rd(4'h0, 32'h000A_0040, "R2 ignored bits");

    // R3 dispatch fan-out, high bits ignored
    wr(4'h8, 32'hFFFF_FFF5);
    chk(irq_valid == 4'b0101, "R3 fanout", 32'(irq_valid), 32'h5);
    expect_cpu(0, 1, 0, 8'h40, "R3 cpu0");
    // R12 activity
    expect_rd(4'h0, 32'h400A_0040, "R12 activity");

    // R3 zero dispatch
    wr(4'h9, 32'hFFFF_FFF0);
    chk(irq_valid == 4'b0101, "R3 zero", 32'(irq_valid), 32'h5);
    expect_rd(4'h1, 32'h800B_0041, "R3 zero no activity");

    // R4 invalid channels
    wr(4'hC, 32'hF);
    wr(4'h5, 32'h000F_00FF);
    expect_rd(4'h5, 32'h0, "R4 invalid read");
    chk(irq_valid == 4'b0101, "R4 invalid dispatch", 32'(irq_valid), 32'h5);

    // R5 mask holds pending
    wr(4'hB, 32'h1);
    expect_cpu(0, 1, 0, 8'h40, "R5 masked");
    wr(4'h3, 32'h000D_0043);
    expect_cpu(0, 1, 3, 8'h43, "R5 unmasked");

    // R6 tie at cpu1
    wr(4'h1, 32'h000C_0041);
    wr(4'h2, 32'h000C_0042);
    wr(4'hA, 32'h2);
    wr(4'h9, 32'h2);
    expect_cpu(1, 1, 1, 8'h41, "R6 tie");

    // R8 / R9 ack at cpu0 only
    pulse(4'b0001, 4'b0000);
    expect_cpu(0, 0, 0, 0, "R9 ceiling");
    expect_cpu(2, 1, 0, 8'h40, "R8 other cpu");
    wr(4'hB, 32'h1);
    expect_cpu(0, 0, 0, 0, "R9 equal blocked");

    // R10 eoi retires
    pulse(4'b0000, 4'b0001);
    expect_cpu(0, 1, 3, 8'h43, "R10 eoi");

    // R11 merge
    wr(4'hB, 32'h1);
    wr(4'hB, 32'h1);
    pulse(4'b0001, 4'b0000);
    pulse(4'b0000, 4'b0001);
    expect_cpu(0, 1, 0, 8'h40, "R11 merge");

    // R8 stray ack, R10 stray eoi
    pulse(4'b1000, 4'b1000);
    expect_cpu(3, 0, 0, 0, "R8 stray ack");
    wr(4'hA, 32'h8);
    expect_cpu(3, 1, 2, 8'h42, "R10 stray eoi");

    // R13 dispatch and ack in one cycle
    ack = 4'b0100;
    wr(4'h8, 32'h4);
    ack = '0;
    expect_cpu(2, 0, 0, 0, "R13 in service");
    pulse(4'b0000, 4'b0100);
    expect_cpu(2, 1, 0, 8'h40, "R13 kept pending");

    repeat (3) tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule